// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the per-source state for a bank of interrupt sources and turns source activity into presentation requests toward a presenter. Each source is fixed at build time as message-type (edge-triggered) or level-type. For each source the block stores a destination server, a priority and a saved priority, along with four status flags: asserted, sent, rejected and masked-pending. A priority of all ones (0xFF) masks the source.

The block takes in the raw source lines and configuration writes aimed at a local source index. It also takes reject and end-of-interrupt (EOI) notices that carry a global source number, plus a request to start a resend pass. Its output is at most one presentation per cycle, made up of a server, a global number and a priority, qualified by a valid strobe. A global number is the local index plus the parameter `BASE`.

The resend pass checks one source per cycle, in index order, and holds `busy` high until it finishes. Several kinds of work can arrive in the same cycle. They are settled in a fixed order: configuration write first, then line events, then reject and EOI, then the scan step. Work that loses arbitration waits; it is not dropped.

Top module: `irq_src_ctrl`

## Requirements
- R1: After a synchronous reset, `pres_valid` and `busy` are 0. Every source has priority and saved priority 0xFF and all status flags clear. Each source keeps its build-time type, given by `LEVEL_MASK` (bit i set means source i is level-type; the default is 8'hF0).
- R2: A source whose priority is 0xFF never produces a presentation, and `pres_prio` is never 0xFF while `pres_valid` is 1.
- R3: A message source is triggered by a rising edge on its line. If it is masked, it sets masked-pending. Otherwise it presents its server, its global number and its priority. The presentation is registered and visible in the cycle after the edge that sampled the trigger. A line that stays high does not trigger again.
- R4: A level source copies its line into the asserted flag on every cycle. A change of the line is an event. On that event the source presents only if it is unmasked, asserted and not sent, and it sets sent when it presents.
- R5: A reject that targets a message source sets its rejected flag. A reject that targets a level source clears its sent flag. A reject never presents anything by itself.
- R6: During a resend pass, a rejected message source clears rejected and presents again if it is unmasked. A level source applies the unmasked, asserted and not-sent rule again.
- R7: An EOI clears sent on a level source. An EOI to a message source changes nothing that a later resend pass could reveal.
- R8: A configuration write replaces the server, priority and saved priority of the target source. A message source with masked-pending set that is now unmasked clears masked-pending and presents in the same step. A level source reruns its level check with the new settings.
- R9: Reject and EOI numbers have `BASE` (default 16) subtracted before indexing. A number outside BASE to BASE+NUM_SRC-1 is ignored. `pres_num` always equals BASE plus the local index.
- R10: `resend_req` while idle raises `busy` on the next cycle. The scan then visits indices 0 to NUM_SRC-1, one per free cycle, and `busy` drops after the last one. A request made while busy is ignored.
- R11: Each cycle at most one source is evaluated and at most one presentation is made. A configuration write wins first, then pending line events (lowest index first), then the scan step. Line events that lose are kept and served later. Reject and EOI apply after a configuration or line evaluation of the same cycle and before its scan evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | NUM_SRC | Source lines, one per local index |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index of the source to configure |
| cfg_server | input | SRV_W | New destination server |
| cfg_prio | input | PRIO_W | New priority (all ones masks) |
| cfg_saved | input | PRIO_W | New saved priority |
| rej_valid | input | 1 | Reject notice strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend_req | input | 1 | Start a resend pass |
| pres_valid | output | 1 | Presentation request valid |
| pres_server | output | SRV_W | Destination server of the request |
| pres_num | output | NUM_W | Global source number of the request |
| pres_prio | output | PRIO_W | Priority of the request |
| busy | output | 1 | Resend pass in progress |

## Verification
The bench aims at the cases where the order of work decides the result:
- Two lines rising together must come out lowest index first on consecutive cycles. A design that dropped the loser would lose an interrupt for good.
- A configuration write that unmasks a message source with masked-pending set must present at once. A design that missed this would leave the trigger stranded.
- A reject followed by a resend must re-present exactly once. Getting the rejected flag wrong shows up either as a missing presentation or as a duplicate on every pass.
- A level source that stays asserted must stay silent until an EOI or a reject clears sent and a resend pass runs. A design that kept no sent state would flood the presenter every cycle.
- Reset must restore masking while keeping each source's type.
- Numbers just outside the global range must be ignored. An error in the base offset would corrupt a neighbouring source.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_CFG  = 2'd1,
        EV_LINE = 2'd2,
        EV_SCAN = 2'd3
    } ev_kind_t;

    typedef struct packed {
        logic asserted;
        logic sent;
        logic rejected;
        logic mpend;
    } src_st_t;

    typedef struct packed {
        src_st_t st;
        logic    fire;
    } eval_res_t;

    // One evaluation step of a source for a given kind of trigger.
    function automatic eval_res_t eval_src(ev_kind_t k, logic lvl, logic masked, src_st_t s);
        eval_res_t r;
        r.st   = s;
        r.fire = 1'b0;
        if (k != EV_NONE) begin
            if (lvl) begin
                if (!masked && s.asserted && !s.sent) begin
                    r.st.sent = 1'b1;
                    r.fire    = 1'b1;
                end
            end else begin
                case (k)
                    EV_LINE: begin
                        if (masked) r.st.mpend = 1'b1;
                        else        r.fire     = 1'b1;
                    end
                    EV_CFG: begin
                        if (s.mpend && !masked) begin
                            r.st.mpend = 1'b0;
                            r.fire     = 1'b1;
                        end
                    end
                    EV_SCAN: begin
                        if (s.rejected) begin
                            r.st.rejected = 1'b0;
                            r.fire        = !masked;
                        end
                    end
                    default: ;
                endcase
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
    import irq_src_pkg::*;
#(
    parameter int SRV_W    = 4,
    parameter int PRIO_W   = 8,
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_in,
    input  logic              cfg_hit,
    input  logic [SRV_W-1:0]  cfg_server,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic [PRIO_W-1:0] cfg_saved,
    input  logic              rej_hit,
    input  logic              eoi_hit,
    input  logic              g_cfg,
    input  logic              g_line,
    input  logic              g_scan,
    output logic              ev_req,
    output logic              fire,
    output logic [SRV_W-1:0]  srv_out,
    output logic [PRIO_W-1:0] prio_out
);

    localparam logic [PRIO_W-1:0] MASK_PRIO = '1;

    logic [SRV_W-1:0]  srv_q, srv_n;
    logic [PRIO_W-1:0] prio_q, prio_n, saved_q, saved_n;
    src_st_t           st_q, st_n;
    logic              line_q, pend_q, pend_n, new_ev, masked;
    eval_res_t         r_cfg, r_line, r_scan;
    src_st_t           s_mid, s_post;

    always_comb begin
        srv_n   = cfg_hit ? cfg_server : srv_q;
        prio_n  = cfg_hit ? cfg_prio   : prio_q;
        saved_n = cfg_hit ? cfg_saved  : saved_q;
        masked  = (prio_n == MASK_PRIO);

        new_ev  = IS_LEVEL ? (line_in != line_q) : (line_in && !line_q);
        ev_req  = pend_q || new_ev;
        pend_n  = ev_req && !g_line;

        // configuration stage
        r_cfg  = eval_src(g_cfg ? EV_CFG : EV_NONE, IS_LEVEL, masked, st_q);
        s_mid  = r_cfg.st;
        // line stage
        if (IS_LEVEL) s_mid.asserted = line_in;
        r_line = eval_src(g_line ? EV_LINE : EV_NONE, IS_LEVEL, masked, s_mid);
        s_post = r_line.st;
        // reject / end-of-interrupt stage
        if (rej_hit) begin
            if (IS_LEVEL) s_post.sent     = 1'b0;
            else          s_post.rejected = 1'b1;
        end
        if (eoi_hit && IS_LEVEL) s_post.sent = 1'b0;
        // scan stage
        r_scan = eval_src(g_scan ? EV_SCAN : EV_NONE, IS_LEVEL, masked, s_post);
        st_n   = r_scan.st;

        fire     = r_cfg.fire || r_line.fire || r_scan.fire;
        srv_out  = srv_n;
        prio_out = prio_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            srv_q   <= '0;
            prio_q  <= MASK_PRIO;
            saved_q <= MASK_PRIO;
            st_q    <= '0;
            line_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            srv_q   <= srv_n;
            prio_q  <= prio_n;
            saved_q <= saved_n;
            st_q    <= st_n;
            line_q  <= line_in;
            pend_q  <= pend_n;
        end
    end

    AST_SAVED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_hit |=> $stable(saved_q)) else $error("saved priority moved"); // R8

    if (IS_LEVEL) begin : g_lvl_chk
        AST_LVL_NO_REJ: assert property (@(posedge clk) disable iff (rst)
            !st_q.rejected && !st_q.mpend) else $error("level flags"); // R5
    end else begin : g_msg_chk
        AST_MSG_NO_SENT: assert property (@(posedge clk) disable iff (rst)
            !st_q.sent && !st_q.asserted) else $error("message flags"); // R7
    end

endmodule

// File: rtl/irq_src_arb.sv
module irq_src_arb #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_ok,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [NUM_SRC-1:0] ev_req,
    input  logic               resend_req,
    output logic [NUM_SRC-1:0] g_cfg,
    output logic [NUM_SRC-1:0] g_line,
    output logic [NUM_SRC-1:0] g_scan,
    output logic               busy
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SRC - 1);

    logic             busy_q, scan_adv;
    logic [IDX_W-1:0] ptr_q;
    int               low_idx;

    always_comb begin
        low_idx = 0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (ev_req[i]) low_idx = i;
        end
        g_cfg    = '0;
        g_line   = '0;
        g_scan   = '0;
        scan_adv = 1'b0;
        if (cfg_ok) begin
            g_cfg[cfg_idx] = 1'b1;
        end else if (|ev_req) begin
            g_line[low_idx] = 1'b1;
        end else if (busy_q) begin
            g_scan[ptr_q] = 1'b1;
            scan_adv      = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ptr_q  <= '0;
        end else if (busy_q) begin
            if (scan_adv) begin
                if (ptr_q == LAST_IDX) begin
                    busy_q <= 1'b0;
                    ptr_q  <= '0;
                end else begin
                    ptr_q <= ptr_q + 1'b1;
                end
            end
        end else if (resend_req) begin
            busy_q <= 1'b1;
            ptr_q  <= '0;
        end
    end

    assign busy = busy_q;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({g_cfg, g_line, g_scan})) else $error("multiple grants"); // R11

    AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> $past(ptr_q) == LAST_IDX) else $error("scan ended early"); // R10

endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl #(
    parameter int                   NUM_SRC    = 8,
    parameter int                   SRV_W      = 4,
    parameter int                   PRIO_W     = 8,
    parameter int                   NUM_W      = 12,
    parameter int                   BASE       = 16,
    parameter logic [NUM_SRC-1:0]   LEVEL_MASK = 8'hF0,
    localparam int                  IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] line_in,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [SRV_W-1:0]   cfg_server,
    input  logic [PRIO_W-1:0]  cfg_prio,
    input  logic [PRIO_W-1:0]  cfg_saved,
    input  logic               rej_valid,
    input  logic [NUM_W-1:0]   rej_num,
    input  logic               eoi_valid,
    input  logic [NUM_W-1:0]   eoi_num,
    input  logic               resend_req,
    output logic               pres_valid,
    output logic [SRV_W-1:0]   pres_server,
    output logic [NUM_W-1:0]   pres_num,
    output logic [PRIO_W-1:0]  pres_prio,
    output logic               busy
);

    localparam logic [NUM_W-1:0]  LO_NUM    = NUM_W'(BASE);
    localparam logic [NUM_W-1:0]  HI_NUM    = NUM_W'(BASE + NUM_SRC);
    localparam logic [PRIO_W-1:0] MASK_PRIO = '1;

    logic               cfg_ok, rej_in, eoi_in;
    logic [NUM_W-1:0]   rej_off, eoi_off;
    logic [NUM_SRC-1:0] ev_req, fire_vec, g_cfg, g_line, g_scan;
    logic [SRV_W-1:0]   slot_srv  [NUM_SRC];
    logic [PRIO_W-1:0]  slot_prio [NUM_SRC];
    logic [SRV_W-1:0]   sel_srv;
    logic [PRIO_W-1:0]  sel_prio;
    logic [NUM_W-1:0]   sel_num;

    always_comb begin
        cfg_ok  = cfg_we && (int'(cfg_idx) < NUM_SRC);
        rej_in  = rej_valid && (rej_num >= LO_NUM) && (rej_num < HI_NUM);
        eoi_in  = eoi_valid && (eoi_num >= LO_NUM) && (eoi_num < HI_NUM);
        rej_off = rej_num - LO_NUM;
        eoi_off = eoi_num - LO_NUM;
    end

    irq_src_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .cfg_ok     (cfg_ok),
        .cfg_idx    (cfg_idx),
        .ev_req     (ev_req),
        .resend_req (resend_req),
        .g_cfg      (g_cfg),
        .g_line     (g_line),
        .g_scan     (g_scan),
        .busy       (busy)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        irq_src_slot #(
            .SRV_W    (SRV_W),
            .PRIO_W   (PRIO_W),
            .IS_LEVEL (LEVEL_MASK[i])
        ) u_slot (
            .clk        (clk),
            .rst        (rst),
            .line_in    (line_in[i]),
            .cfg_hit    (cfg_ok && (int'(cfg_idx) == i)),
            .cfg_server (cfg_server),
            .cfg_prio   (cfg_prio),
            .cfg_saved  (cfg_saved),
            .rej_hit    (rej_in && (rej_off == NUM_W'(i))),
            .eoi_hit    (eoi_in && (eoi_off == NUM_W'(i))),
            .g_cfg      (g_cfg[i]),
            .g_line     (g_line[i]),
            .g_scan     (g_scan[i]),
            .ev_req     (ev_req[i]),
            .fire       (fire_vec[i]),
            .srv_out    (slot_srv[i]),
            .prio_out   (slot_prio[i])
        );
    end

    always_comb begin
        sel_srv  = '0;
        sel_prio = '0;
        sel_num  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (fire_vec[i]) begin
                sel_srv  = sel_srv  | slot_srv[i];
                sel_prio = sel_prio | slot_prio[i];
                sel_num  = sel_num  | NUM_W'(BASE + i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pres_valid  <= 1'b0;
            pres_server <= '0;
            pres_num    <= '0;
            pres_prio   <= '0;
        end else begin
            pres_valid  <= |fire_vec;
            pres_server <= sel_srv;
            pres_num    <= sel_num;
            pres_prio   <= sel_prio;
        end
    end

    AST_ONE_FIRE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fire_vec)) else $error("two sources fired"); // R11

    AST_PRES_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        pres_valid |-> pres_prio != MASK_PRIO) else $error("masked presented"); // R2

    AST_PRES_RANGE: assert property (@(posedge clk) disable iff (rst)
        pres_valid |-> (pres_num >= LO_NUM) && (pres_num < HI_NUM)) else $error("number out of range"); // R9

endmodule

// File: tb/sim_irq_src_ctrl.sv
module sim_irq_src_ctrl;

    localparam int N    = 8;
    localparam int BASE = 16;
    localparam logic [N-1:0] LVL = 8'hF0;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] line_in = '0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_idx = '0;
    logic [3:0]   cfg_server = '0;
    logic [7:0]   cfg_prio = '0, cfg_saved = '0;
    logic         rej_valid = 1'b0, eoi_valid = 1'b0, resend_req = 1'b0;
    logic [11:0]  rej_num = '0, eoi_num = '0;
    logic         pres_valid, busy;
    logic [3:0]   pres_server;
    logic [11:0]  pres_num;
    logic [7:0]   pres_prio;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    armed = 0, done = 0;

    always #10 clk = ~clk;

    irq_src_ctrl u0 (
        .clk(clk), .rst(rst), .line_in(line_in), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_server(cfg_server), .cfg_prio(cfg_prio), .cfg_saved(cfg_saved),
        .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
        .resend_req(resend_req), .pres_valid(pres_valid), .pres_server(pres_server),
        .pres_num(pres_num), .pres_prio(pres_prio), .busy(busy)
    );

    // behavioural reference model
    int m_prio [N];
    int m_srv  [N];
    bit m_ast [N], m_sent [N], m_rej [N], m_mp [N], m_prev [N], m_pend [N];
    int m_ptr;
    bit m_busy;
    bit e_valid;
    int e_srv, e_num, e_prio;

    task automatic m_eval(int s, int kind, ref bit f, ref int fs);
        bit lvl = LVL[s];
        bit msk = (m_prio[s] == 255);
        if (lvl) begin
            if (!msk && m_ast[s] && !m_sent[s]) begin m_sent[s] = 1; f = 1; fs = s; end
        end else if (kind == 2) begin
            if (msk) m_mp[s] = 1; else begin f = 1; fs = s; end
        end else if (kind == 1) begin
            if (m_mp[s] && !msk) begin m_mp[s] = 0; f = 1; fs = s; end
        end else if (kind == 3) begin
            if (m_rej[s]) begin m_rej[s] = 0; if (!msk) begin f = 1; fs = s; end end
        end
    endtask

    task automatic model_step();
        bit f = 0;
        int fs = 0, who = -1, kind = 0, ri, ei;
        bit oldbusy = m_busy;
        bit newev [N];
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_prio[i] = 255; m_srv[i] = 0; m_ast[i] = 0; m_sent[i] = 0;
                m_rej[i] = 0; m_mp[i] = 0; m_prev[i] = 0; m_pend[i] = 0;
            end
            m_ptr = 0; m_busy = 0; e_valid = 0;
            return;
        end
        for (int i = 0; i < N; i++) begin
            newev[i] = LVL[i] ? (line_in[i] != m_prev[i]) : (line_in[i] && !m_prev[i]);
            m_pend[i] = m_pend[i] || newev[i];
        end
        if (cfg_we) begin
            who = cfg_idx; kind = 1;
            m_srv[who] = cfg_server; m_prio[who] = cfg_prio;
        end else begin
            for (int i = N - 1; i >= 0; i--) if (m_pend[i]) begin who = i; kind = 2; end
            if (kind == 0 && oldbusy) begin who = m_ptr; kind = 3; end
        end
        if (kind == 1) m_eval(who, 1, f, fs);
        for (int i = 0; i < N; i++) if (LVL[i]) m_ast[i] = line_in[i];
        if (kind == 2) begin m_eval(who, 2, f, fs); m_pend[who] = 0; end
        ri = int'(rej_num) - BASE;
        ei = int'(eoi_num) - BASE;
        if (rej_valid && ri >= 0 && ri < N) begin
            if (LVL[ri]) m_sent[ri] = 0; else m_rej[ri] = 1;
        end
        if (eoi_valid && ei >= 0 && ei < N && LVL[ei]) m_sent[ei] = 0;
        if (kind == 3) begin
            m_eval(who, 3, f, fs);
            if (m_ptr == N - 1) begin m_ptr = 0; m_busy = 0; end else m_ptr++;
        end
        if (!oldbusy && resend_req) begin m_busy = 1; m_ptr = 0; end
        for (int i = 0; i < N; i++) m_prev[i] = line_in[i];
        e_valid = f;
        e_srv = m_srv[fs]; e_num = BASE + fs; e_prio = m_prio[fs];
    endtask

    always @(posedge clk) begin
        model_step();
        armed <= 1;
    end

    task automatic chk(string tag, bit ok, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (armed && !done) begin
        chk(cur_req, pres_valid == e_valid, "pres_valid", pres_valid, e_valid);
        chk(cur_req, busy == m_busy, "busy", busy, m_busy);
        if (e_valid && pres_valid) begin
            chk(cur_req, pres_num == e_num, "pres_num", pres_num, e_num);
            chk(cur_req, pres_server == e_srv, "pres_server", pres_server, e_srv);
            chk(cur_req, pres_prio == e_prio, "pres_prio", pres_prio, e_prio);
        end
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic expect_pres(string tag, bit v, int srv, int num, int prio);
        chk(tag, pres_valid == v, "pres_valid", pres_valid, v);
        if (v) begin
            chk(tag, pres_num == num, "pres_num", pres_num, num);
            chk(tag, pres_server == srv, "pres_server", pres_server, srv);
            chk(tag, pres_prio == prio, "pres_prio", pres_prio, prio);
        end
    endtask

    task automatic cfg(int idx, int srv, int prio);
        cfg_we = 1; cfg_idx = 3'(idx); cfg_server = 4'(srv); cfg_prio = 8'(prio); cfg_saved = 8'(prio + 1);
    endtask

    task automatic run_resend();
        resend_req = 1; tick(); resend_req = 0;
        for (int k = 0; k < 40 && busy; k++) tick();
        repeat (2) tick();
    endtask

    initial begin
        int n;
        repeat (3) tick();
        rst = 0; tick();
        cur_req = "R1";
        expect_pres("R1", 0, 0, 0, 0);
        chk("R1", busy == 0, "busy", busy, 0);

        cur_req = "R3";
        line_in[1] = 1; tick(); expect_pres("R3", 0, 0, 0, 0);
        line_in[1] = 0; tick();

        cur_req = "R8";
        cfg(1, 3, 5); tick(); cfg_we = 0;
        expect_pres("R8", 1, 3, 17, 5);
        tick(); expect_pres("R8", 0, 0, 0, 0);

        cur_req = "R3";
        line_in[1] = 1; tick(); expect_pres("R3", 1, 3, 17, 5);
        tick(); expect_pres("R3", 0, 0, 0, 0);
        line_in[1] = 0; tick();

        cur_req = "R5";
        rej_valid = 1; rej_num = 17; tick(); rej_valid = 0;
        expect_pres("R5", 0, 0, 0, 0);

        cur_req = "R10";
        resend_req = 1; tick(); resend_req = 0;
        chk("R10", busy == 1, "busy", busy, 1);
        cur_req = "R6";
        tick(); tick(); expect_pres("R6", 1, 3, 17, 5);
        n = 0;
        while (busy && n < 20) begin resend_req = 1; tick(); n++; end
        resend_req = 0;
        chk("R10", n == 6, "cycles to idle", n, 6);
        run_resend();

        cur_req = "R4";
        cfg(5, 1, 2); tick(); cfg_we = 0; expect_pres("R8", 0, 0, 0, 0);
        line_in[5] = 1; tick(); expect_pres("R4", 1, 1, 21, 2);
        tick(); tick(); expect_pres("R4", 0, 0, 0, 0);

        cur_req = "R7";
        eoi_valid = 1; eoi_num = 21; tick(); eoi_valid = 0;
        expect_pres("R7", 0, 0, 0, 0);
        eoi_num = 17; eoi_valid = 1; tick(); eoi_valid = 0;
        cur_req = "R6";
        run_resend();
        cur_req = "R5";
        rej_valid = 1; rej_num = 21; tick(); rej_valid = 0;
        run_resend();

        cur_req = "R9";
        rej_valid = 1; rej_num = 15; eoi_valid = 1; eoi_num = 24; tick();
        rej_num = 24; eoi_num = 15; tick();
        rej_valid = 0; eoi_valid = 0;
        run_resend();

        cur_req = "R11";
        cfg(0, 2, 4); tick(); cfg(6, 0, 3); tick();
        cfg(2, 7, 7); line_in[0] = 1; line_in[6] = 1; tick(); cfg_we = 0;
        expect_pres("R11", 0, 0, 0, 0);
        tick(); expect_pres("R11", 1, 2, 16, 4);
        tick(); expect_pres("R11", 1, 0, 22, 3);
        line_in[0] = 0; tick();
        rej_valid = 1; rej_num = 16; tick(); rej_valid = 0;
        resend_req = 1; tick(); resend_req = 0;
        line_in[7] = 1; line_in[4] = 1; tick(); line_in[6] = 0; tick();
        eoi_valid = 1; eoi_num = 22; rej_valid = 1; rej_num = 16; tick();
        eoi_valid = 0; rej_valid = 0;
        repeat (12) tick();

        cur_req = "R2";
        cfg(0, 1, 255); tick(); cfg_we = 0;
        line_in[0] = 1; tick(); expect_pres("R2", 0, 0, 0, 0);
        line_in[0] = 0; tick();
        cur_req = "R8";
        cfg(0, 1, 9); tick(); cfg_we = 0; expect_pres("R8", 1, 1, 16, 9);
        tick();

        cur_req = "R1";
        rst = 1; tick(); tick(); rst = 0;
        repeat (6) tick();
        expect_pres("R1", 0, 0, 0, 0);
        line_in[1] = 1; tick(); expect_pres("R1", 0, 0, 0, 0);
        cur_req = "R8";
        cfg(5, 2, 6); tick(); cfg_we = 0; expect_pres("R8", 1, 2, 21, 6);
        repeat (4) tick();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule